// File: doc/BRIEF.md
# Binary32 to Integer Converter

The converter takes one packed single-precision floating-point word and produces a 32-bit integer, either two's-complement signed or unsigned, chosen per operation by a mode input. The fractional part is rounded under one of four rounding modes. A force input overrides the selected mode with truncation toward zero, which serves conversions that always truncate.

Three flags come back with each result. Invalid reports saturation, a NaN or infinity, or a negative value that cannot be written as unsigned. Inexact reports that fraction bits were discarded. Input-denormal reports a subnormal operand. The conversion logic is purely combinational. A single register stage holds the result and the flags, and `out_valid` marks them one cycle after `in_valid`.

Top module: `f2i_convert`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and the result and flags belong to that input. `out_valid` is low after an edge where `in_valid` was low. An active-low asynchronous reset clears `out_valid`, `out_int` and all three flags.
- R2: `rnd_mode` encodes 0 as nearest with ties to even, 1 as toward +infinity, 2 as toward -infinity and 3 as toward zero. The mode is applied to the magnitude's discarded fraction, with the sign taken into account. When `force_rtz` is high, mode 3 is used regardless of `rnd_mode`.
- R3: An input with an unbiased exponent of 32 or more saturates and raises invalid, with inexact clear. This includes infinities and NaNs. Unsigned results are 0x00000000 if negative and 0xFFFFFFFF otherwise. Signed results are 0x80000000 if negative and 0x7FFFFFFF otherwise.
- R4: An unsigned conversion treats a NaN as positive and gives 0xFFFFFFFF. A signed conversion keeps the NaN's sign bit.
- R5: For a representable in-range input, a nonzero discarded fraction raises inexact. An exact value raises no flag.
- R6: An unsigned conversion of a negative value whose rounded magnitude is nonzero gives 0 and raises invalid, with inexact clear. A negative value whose magnitude rounds to 0 gives 0 with only inexact raised.
- R7: A signed conversion whose rounded magnitude exceeds 0x7FFFFFFF (positive) or 0x80000000 (negative) saturates to 0x7FFFFFFF or 0x80000000 and raises invalid. An exact -2^31 gives 0x80000000 with no flag.
- R8: A nonzero magnitude below one half gives 0 with inexact raised. With mode 1 and a positive input the result is 1. With mode 2 and a negative input, a signed conversion gives 0xFFFFFFFF. An unsigned conversion in that case gives 0 and also raises invalid.
- R9: A subnormal input (exponent field 0, fraction nonzero) raises the input-denormal flag and is then converted by the rule of R8.
- R10: +0 and -0 convert to 0 with no flag raised, in every mode.
- R11: A signed conversion of a negative in-range value returns the two's complement of the rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_bits | input | 32 | Packed binary32 operand |
| in_signed | input | 1 | 1: signed result, 0: unsigned result |
| rnd_mode | input | 2 | Rounding mode, encoding in R2 |
| force_rtz | input | 1 | Forces round toward zero |
| out_valid | output | 1 | Result and flags are valid |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The halfway values 0.5, 1.5 and 2.5 under nearest rounding tell ties-to-even apart from ties-away, and 0.75 shows that a remainder above the half point carries. Running ±2.5 through all three directed modes, with and without the force input, shows whether the increment follows the sign or only the mode. Values on either side of 2^31 and 2^32, together with infinities and NaNs of both signs, tell the signed limits from the unsigned ones. A -2^31 input shows whether the negative bound is one larger. Quarters, halves and subnormals of both signs separate the below-one-half path from the shifted path.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_UP      = 2'd1,
      RM_DOWN    = 2'd2,
      RM_ZERO    = 2'd3
   } rmode_e;

   typedef enum logic [1:0] {
      RNG_SMALL = 2'd0,
      RNG_MID   = 2'd1,
      RNG_BIG   = 2'd2
   } range_e;

   typedef struct packed {
      logic invalid;
      logic inexact;
      logic denorm;
   } flags_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
   import f2i_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32,
   parameter int SH_W  = $clog2(INT_W + 1)
) (
   input  logic [EXP_W+MAN_W:0] bits,
   input  logic                 signed_mode,
   output logic                 sign_eff,
   output range_e               range,
   output logic                 nonzero,
   output logic                 denorm,
   output logic [SH_W-1:0]      shift,
   output logic [INT_W-1:0]     mant
);
   localparam int EW  = EXP_W + 2;
   localparam int PAD = INT_W - MAN_W - 1;
   localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (EXP_W - 1)) - 1);
   localparam logic signed [EW-1:0] LIM_HI = EW'(INT_W);
   localparam logic signed [EW-1:0] LIM_LO = EW'(-1);
   localparam logic signed [EW-1:0] TOP_S  = EW'(INT_W - 1);

   logic                 sgn;
   logic [EXP_W-1:0]     exp_f;
   logic [MAN_W-1:0]     frac;
   logic                 is_nan;
   logic signed [EW-1:0] e_unb;

   assign sgn   = bits[EXP_W+MAN_W];
   assign exp_f = bits[EXP_W+MAN_W-1:MAN_W];
   assign frac  = bits[MAN_W-1:0];

   assign is_nan   = (&exp_f) && (|frac);
   assign sign_eff = sgn & ~(is_nan & ~signed_mode);
   assign nonzero  = (|exp_f) | (|frac);
   assign denorm   = (exp_f == '0) && (|frac);

   assign e_unb = $signed({2'b00, exp_f}) - BIAS_S;

   always_comb begin
      if (e_unb >= LIM_HI)      range = RNG_BIG;
      else if (e_unb >= LIM_LO) range = RNG_MID;
      else                      range = RNG_SMALL;
   end

   // distance from the integer LSB; meaningful only in the middle range
   assign shift = SH_W'(TOP_S - e_unb);
   assign mant  = {(|exp_f), frac, {PAD{1'b0}}};

endmodule

// File: rtl/f2i_round.sv
module f2i_round
   import f2i_pkg::*;
#(
   parameter int INT_W = 32,
   parameter int SH_W  = $clog2(INT_W + 1)
) (
   input  logic [INT_W-1:0] mant,
   input  logic [SH_W-1:0]  shift,
   input  logic             sign,
   input  rmode_e           rmode,
   output logic [INT_W-1:0] int_part,
   output logic [INT_W-1:0] rem,
   output logic             carry
);
   localparam logic [INT_W-1:0] HALF     = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] HALF_LO  = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] ALL_ONES = '1;

   logic [2*INT_W-1:0] wide;
   logic [INT_W-1:0]   incr;

   assign wide     = {mant, {INT_W{1'b0}}} >> shift;
   assign int_part = wide[2*INT_W-1:INT_W];
   assign rem      = wide[INT_W-1:0];

   always_comb begin
      incr = '0;
      unique case (rmode)
         RM_NEAREST: incr = int_part[0] ? HALF : HALF_LO;
         RM_ZERO:    incr = '0;
         RM_UP:      incr = sign ? '0 : ALL_ONES;
         RM_DOWN:    incr = sign ? ALL_ONES : '0;
         default:    incr = '0;
      endcase
   end

   // rem + incr leaves the word exactly when rem exceeds ~incr
   assign carry = (rem > ~incr);

endmodule

// File: rtl/f2i_finish.sv
module f2i_finish
   import f2i_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  range_e           range,
   input  logic             signed_mode,
   input  logic             sign,
   input  logic             nonzero,
   input  logic             denorm,
   input  rmode_e           rmode,
   input  logic [INT_W-1:0] int_part,
   input  logic [INT_W-1:0] rem,
   input  logic             carry,
   output logic [INT_W-1:0] result,
   output flags_t           flags
);
   localparam logic [INT_W-1:0] ALL_ONES = '1;
   localparam logic [INT_W-1:0] S_MAX    = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] S_MIN    = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] ONE      = {{(INT_W-1){1'b0}}, 1'b1};

   logic [INT_W-1:0] bumped;
   logic [INT_W-1:0] s_lim;
   logic [INT_W-1:0] s_mag;

   assign bumped = (carry && int_part != ALL_ONES) ? int_part + ONE : int_part;
   assign s_lim  = sign ? S_MIN : S_MAX;

   always_comb begin
      result        = '0;
      flags.invalid = 1'b0;
      flags.inexact = 1'b0;
      flags.denorm  = denorm;
      s_mag         = '0;
      unique case (range)
         RNG_BIG: begin
            flags.invalid = 1'b1;
            if (signed_mode) result = s_lim;
            else             result = sign ? '0 : ALL_ONES;
         end
         RNG_MID: begin
            if (!signed_mode) begin
               flags.invalid = carry && (int_part == ALL_ONES);
               if (sign && bumped != '0) begin
                  result        = '0;
                  flags.invalid = 1'b1;
               end else begin
                  result        = bumped;
                  flags.inexact = (rem != '0);
               end
            end else begin
               if (bumped > s_lim) begin
                  s_mag         = s_lim;
                  flags.invalid = 1'b1;
               end else begin
                  s_mag         = bumped;
                  flags.inexact = (rem != '0);
               end
               result = sign ? (~s_mag + ONE) : s_mag;
            end
         end
         default: begin
            if (nonzero) begin
               flags.inexact = 1'b1;
               if (rmode == RM_UP && !sign) begin
                  result = ONE;
               end else if (rmode == RM_DOWN && sign) begin
                  if (signed_mode) result = ALL_ONES;
                  else             flags.invalid = 1'b1;
               end
            end
         end
      endcase
   end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
   import f2i_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [EXP_W+MAN_W:0] in_bits,
   input  logic                 in_signed,
   input  logic [1:0]           rnd_mode,
   input  logic                 force_rtz,
   output logic                 out_valid,
   output logic [INT_W-1:0]     out_int,
   output logic                 out_invalid,
   output logic                 out_inexact,
   output logic                 out_denorm
);
   localparam int SH_W = $clog2(INT_W + 1);
   localparam int TOPB = EXP_W + MAN_W;

   if (INT_W < MAN_W + 2) begin : g_chk_width
      $error("INT_W must exceed MAN_W + 1");
   end
   if (EXP_W < 3 || INT_W >= (1 << (EXP_W - 1))) begin : g_chk_exp
      $error("EXP_W too small for INT_W");
   end

   rmode_e           eff_mode;
   logic             sign_eff;
   range_e           range;
   logic             nonzero;
   logic             denorm;
   logic [SH_W-1:0]  shift;
   logic [INT_W-1:0] mant;
   logic [INT_W-1:0] int_part;
   logic [INT_W-1:0] rem;
   logic             carry;
   logic [INT_W-1:0] result;
   flags_t           flags;

   assign eff_mode = force_rtz ? RM_ZERO : rmode_e'(rnd_mode);

   f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .SH_W(SH_W)) i_unpack (
      .bits        (in_bits),
      .signed_mode (in_signed),
      .sign_eff    (sign_eff),
      .range       (range),
      .nonzero     (nonzero),
      .denorm      (denorm),
      .shift       (shift),
      .mant        (mant)
   );

   f2i_round #(.INT_W(INT_W), .SH_W(SH_W)) i_round (
      .mant     (mant),
      .shift    (shift),
      .sign     (sign_eff),
      .rmode    (eff_mode),
      .int_part (int_part),
      .rem      (rem),
      .carry    (carry)
   );

   f2i_finish #(.INT_W(INT_W)) i_finish (
      .range       (range),
      .signed_mode (in_signed),
      .sign        (sign_eff),
      .nonzero     (nonzero),
      .denorm      (denorm),
      .rmode       (eff_mode),
      .int_part    (int_part),
      .rem         (rem),
      .carry       (carry),
      .result      (result),
      .flags       (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_int     <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
         out_denorm  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_int     <= result;
            out_invalid <= flags.invalid;
            out_inexact <= flags.inexact;
            out_denorm  <= flags.denorm;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (&in_bits[TOPB-1:MAN_W]) |=> out_invalid && !out_inexact); // R3
   AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_signed && in_bits[TOPB] && !((&in_bits[TOPB-1:MAN_W]) && (|in_bits[MAN_W-1:0]))
      |=> out_int == '0); // R6
   AST_DENORM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_bits[TOPB-1:MAN_W] == '0) && (|in_bits[MAN_W-1:0]) |=> out_denorm); // R9
   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_bits[TOPB-1:0] == '0)
      |=> out_int == '0 && !out_invalid && !out_inexact && !out_denorm); // R10

endmodule

// File: tb/test_f2i_convert.sv
module test_f2i_convert;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 32;

   // {req[3:0], bits[31:0], signed, mode[1:0], rtz, expected[31:0], flags{inv,inx,den}}
   localparam logic [74:0] VEC [NV] = '{
      {4'd2,  32'h3FC00000, 1'b1, 2'd0, 1'b0, 32'h00000002, 3'b010}, // R2 1.5 tie up to even
      {4'd2,  32'h40200000, 1'b1, 2'd0, 1'b0, 32'h00000002, 3'b010}, // R2 2.5 tie down to even
      {4'd2,  32'h3F000000, 1'b1, 2'd0, 1'b0, 32'h00000000, 3'b010}, // R2 0.5 tie to 0
      {4'd2,  32'h3F400000, 1'b1, 2'd0, 1'b0, 32'h00000001, 3'b010}, // R2 0.75 above half
      {4'd11, 32'hBFC00000, 1'b1, 2'd0, 1'b0, 32'hFFFFFFFE, 3'b010}, // R11 -1.5 -> -2
      {4'd2,  32'hC0200000, 1'b1, 2'd1, 1'b0, 32'hFFFFFFFE, 3'b010}, // R2 -2.5 up
      {4'd2,  32'hC0200000, 1'b1, 2'd2, 1'b0, 32'hFFFFFFFD, 3'b010}, // R2 -2.5 down
      {4'd2,  32'h40200000, 1'b1, 2'd1, 1'b0, 32'h00000003, 3'b010}, // R2 2.5 up
      {4'd2,  32'h40200000, 1'b1, 2'd2, 1'b0, 32'h00000002, 3'b010}, // R2 2.5 down
      {4'd2,  32'h40200000, 1'b1, 2'd1, 1'b1, 32'h00000002, 3'b010}, // R2 force overrides up
      {4'd5,  32'h42C80000, 1'b0, 2'd0, 1'b0, 32'h00000064, 3'b000}, // R5 100.0 exact
      {4'd7,  32'h4F000000, 1'b1, 2'd0, 1'b0, 32'h7FFFFFFF, 3'b100}, // R7 2^31 signed
      {4'd7,  32'hCF000000, 1'b1, 2'd0, 1'b0, 32'h80000000, 3'b000}, // R7 -2^31 exact
      {4'd5,  32'h4F000000, 1'b0, 2'd0, 1'b0, 32'h80000000, 3'b000}, // R5 2^31 unsigned
      {4'd5,  32'h4F7FFFFF, 1'b0, 2'd1, 1'b0, 32'hFFFFFF00, 3'b000}, // R5 largest below 2^32
      {4'd3,  32'h4F800000, 1'b0, 2'd0, 1'b0, 32'hFFFFFFFF, 3'b100}, // R3 2^32 unsigned
      {4'd3,  32'h4F800000, 1'b1, 2'd0, 1'b0, 32'h7FFFFFFF, 3'b100}, // R3 2^32 signed
      {4'd3,  32'hFF800000, 1'b1, 2'd0, 1'b0, 32'h80000000, 3'b100}, // R3 -inf signed
      {4'd3,  32'hFF800000, 1'b0, 2'd0, 1'b0, 32'h00000000, 3'b100}, // R3 -inf unsigned
      {4'd4,  32'hFFC00000, 1'b0, 2'd0, 1'b0, 32'hFFFFFFFF, 3'b100}, // R4 -NaN unsigned
      {4'd4,  32'hFFC00000, 1'b1, 2'd0, 1'b0, 32'h80000000, 3'b100}, // R4 -NaN signed
      {4'd6,  32'hBFC00000, 1'b0, 2'd0, 1'b0, 32'h00000000, 3'b100}, // R6 -1.5 unsigned
      {4'd6,  32'hBF000000, 1'b0, 2'd0, 1'b0, 32'h00000000, 3'b010}, // R6 -0.5 rounds to 0
      {4'd8,  32'h3E800000, 1'b1, 2'd1, 1'b0, 32'h00000001, 3'b010}, // R8 0.25 up
      {4'd8,  32'h3E800000, 1'b1, 2'd0, 1'b0, 32'h00000000, 3'b010}, // R8 0.25 nearest
      {4'd8,  32'hBE800000, 1'b1, 2'd2, 1'b0, 32'hFFFFFFFF, 3'b010}, // R8 -0.25 down signed
      {4'd8,  32'hBE800000, 1'b0, 2'd2, 1'b0, 32'h00000000, 3'b110}, // R8 -0.25 down unsigned
      {4'd9,  32'h00000001, 1'b1, 2'd1, 1'b0, 32'h00000001, 3'b011}, // R9 subnormal up
      {4'd9,  32'h80000001, 1'b1, 2'd0, 1'b0, 32'h00000000, 3'b011}, // R9 -subnormal nearest
      {4'd10, 32'h00000000, 1'b1, 2'd1, 1'b0, 32'h00000000, 3'b000}, // R10 +0
      {4'd10, 32'h80000000, 1'b0, 2'd2, 1'b0, 32'h00000000, 3'b000}, // R10 -0
      {4'd5,  32'h40400000, 1'b1, 2'd2, 1'b1, 32'h00000003, 3'b000}  // R5 3.0 exact
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_bits;
   logic        in_signed;
   logic [1:0]  rnd_mode;
   logic        force_rtz;
   logic        out_valid;
   logic [31:0] out_int;
   logic        out_invalid;
   logic        out_inexact;
   logic        out_denorm;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   f2i_convert i_f2i_convert (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_bits     (in_bits),
      .in_signed   (in_signed),
      .rnd_mode    (rnd_mode),
      .force_rtz   (force_rtz),
      .out_valid   (out_valid),
      .out_int     (out_int),
      .out_invalid (out_invalid),
      .out_inexact (out_inexact),
      .out_denorm  (out_denorm)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input logic [3:0] fa, input logic [3:0] fe);
      n_tests++;
      if (act !== exp || fa !== fe) begin
         n_fail++;
         $display("FAIL %s: int/{valid,inv,inx,den} actual %h/%b expected %h/%b",
                  req, act, fa, exp, fe);
      end
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_bits = '0;
      in_signed = 1'b0; rnd_mode = 2'd0; force_rtz = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset", out_int, 32'h0, {out_valid, out_invalid, out_inexact, out_denorm}, 4'b0000);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         in_valid  = 1'b1;
         in_bits   = VEC[i][70:39];
         in_signed = VEC[i][38];
         rnd_mode  = VEC[i][37:36];
         force_rtz = VEC[i][35];
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i][74:71], i), out_int, VEC[i][34:3],
               {out_valid, out_invalid, out_inexact, out_denorm}, {1'b1, VEC[i][2:0]});
      end
      // R1 idle cycle: valid drops, captured result of the last vector holds
      in_valid = 1'b0;
      in_bits  = 32'h4F800000;
      @(negedge clk);
      check("R1 idle", out_int, 32'h00000003, {out_valid, out_invalid, out_inexact, out_denorm}, 4'b0000);
      // R1 back-to-back after idle
      in_valid = 1'b1; in_bits = 32'hC0200000; in_signed = 1'b1; rnd_mode = 2'd3; force_rtz = 1'b0;
      @(negedge clk);
      check("R1 restart", out_int, 32'hFFFFFFFE, {out_valid, out_invalid, out_inexact, out_denorm}, 4'b1010);
      // R1 asynchronous reset in mid-run clears outputs
      in_valid = 1'b0;
      #(CLK_PERIOD / 4) rst_n = 1'b0;
      #1;
      check("R1 async reset", out_int, 32'h0, {out_valid, out_invalid, out_inexact, out_denorm}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule